// File: doc/BRIEF.md
# Segmented kernel address translator

This block sits ahead of a page-based memory management unit and classifies every 32-bit virtual address into one of three routes. The address passes through untouched when translation is switched off. It is remapped through a small per-segment base table when a kernel access hits an enabled segment. Otherwise it is handed to the page lookup. Remapped and untranslated accesses carry full read, write and execute permission and never miss.

The top four address bits name one of sixteen segments. A segment-enable vector picks which segments are remapped. Two packed 32-bit base registers each hold eight 4-bit base values, the low register for segments 0 to 7 and the high register for segments 8 to 15. The base value replaces the top nibble of the address, and the lower 28 bits are kept. All configuration arrives as plain input vectors.

A request strobe loads one registered result stage. The result is valid one cycle later and then holds until the next strobe.

Top module: `seg_xlat_top`

## Requirements
- R1: During and right after reset, valid_o, page_lookup_o, paddr_o and all three permission outputs are 0.
- R2: valid_o is 1 in exactly the cycle after a cycle with req_i high, and is 0 otherwise.
- R3: Translation counts as enabled when bit 2 or bit 3 of gcfg_i is 1. All other gcfg_i bits have no effect.
- R4: With translation disabled, paddr_o equals vaddr_i, perm_r_o, perm_w_o and perm_x_o are 1, and page_lookup_o is 0, whatever the other inputs are.
- R5: The segment number is vaddr_i[31:28]. With translation enabled, an access is remapped only when user_i is 0 and mcfg_i[segment] is 1.
- R6: A remapped segment s below 8 takes its base from base_lo_i[4*s+3:4*s]. A segment s of 8 or above takes its base from base_hi_i[4*(s-8)+3:4*(s-8)].
- R7: A remapped access gives paddr_o = {base, vaddr_i[27:0]}, sets all three permissions to 1, and sets page_lookup_o to 0.
- R8: With translation enabled, a user-mode access (user_i = 1) is never remapped, even when every segment is enabled.
- R9: When translation is enabled and no remap applies, page_lookup_o is 1, all three permissions are 0, and paddr_o carries vaddr_i unchanged.
- R10: In cycles without req_i, paddr_o, the permissions and page_lookup_o keep their last values, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; loads the result stage |
| vaddr_i | input | 32 | Virtual address |
| user_i | input | 1 | 1 = user-mode access, 0 = kernel |
| gcfg_i | input | 32 | Global config; bits 3:2 enable translation |
| mcfg_i | input | 32 | Segment-enable vector, bit s for segment s |
| base_lo_i | input | 32 | Base nibbles of segments 0 to 7 |
| base_hi_i | input | 32 | Base nibbles of segments 8 to 15 |
| valid_o | output | 1 | Result valid, one cycle after req_i |
| paddr_o | output | 32 | Physical address, or the virtual address when page lookup is needed |
| perm_r_o | output | 1 | Read permitted |
| perm_w_o | output | 1 | Write permitted |
| perm_x_o | output | 1 | Execute permitted |
| page_lookup_o | output | 1 | Address must be resolved by the page lookup |

## Verification
Every result is due exactly one clock edge after the strobe. valid_o rises in that cycle and falls one edge later, and paddr_o, the permissions and page_lookup_o are loaded at the same edge and then hold. The bench changes inputs on the falling clock edge and raises req_i for one cycle. It samples all outputs on the next falling edge, half a period after the loading edge, and compares them with values it computes from the requirements. The hold checks take place two idle cycles later, after the inputs have been changed.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned SEG_W    = 4;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned NUM_SEG  = 1 << SEG_W;
  localparam int unsigned HALF_SEG = NUM_SEG / 2;
  localparam int unsigned BASE_W   = HALF_SEG * SEG_W;

  typedef enum logic [1:0] {
    ROUTE_BYPASS  = 2'd0,
    ROUTE_SEGMENT = 2'd1,
    ROUTE_PAGE    = 2'd2
  } route_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;
endpackage

// File: rtl/seg_xlat_enable_dec.sv
module seg_xlat_enable_dec #(
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned EN_LSB = 2,
  parameter int unsigned EN_MSB = 3
) (
  input  logic [CFG_W-1:0] gcfg_i,
  output logic             mmu_on_o
);
  localparam int unsigned EN_CNT = EN_MSB - EN_LSB + 1;
  localparam logic [CFG_W-1:0] EN_MASK = {{(CFG_W-EN_CNT){1'b0}}, {EN_CNT{1'b1}}} << EN_LSB;

  // a mask keeps every config bit in use while only the enable field counts
  assign mmu_on_o = |(gcfg_i & EN_MASK);
endmodule

// File: rtl/seg_xlat_base_sel.sv
module seg_xlat_base_sel #(
  parameter int unsigned SEG_W = 4
) (
  input  logic [SEG_W-1:0]                   seg_i,
  input  logic [(1<<SEG_W)/2*SEG_W-1:0]      base_lo_i,
  input  logic [(1<<SEG_W)/2*SEG_W-1:0]      base_hi_i,
  output logic [SEG_W-1:0]                   base_o
);
  localparam int unsigned NUM_SEG  = 1 << SEG_W;
  localparam int unsigned HALF_SEG = NUM_SEG / 2;

  logic [SEG_W-1:0] base_tbl [NUM_SEG];

  for (genvar g = 0; g < HALF_SEG; g++) begin : g_slot
    assign base_tbl[g]          = base_lo_i[g*SEG_W +: SEG_W];
    assign base_tbl[g+HALF_SEG] = base_hi_i[g*SEG_W +: SEG_W];
  end

  assign base_o = base_tbl[seg_i];
endmodule

// File: rtl/seg_xlat_route.sv
module seg_xlat_route
  import seg_xlat_pkg::*;
#(
  parameter int unsigned SEG_W = 4,
  parameter int unsigned CFG_W = 32
) (
  input  logic             mmu_on_i,
  input  logic             user_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [CFG_W-1:0] mcfg_i,
  output route_e           route_o
);
  logic seg_en;

  assign seg_en = mcfg_i[seg_i];

  always_comb begin
    if (!mmu_on_i)                 route_o = ROUTE_BYPASS;
    else if (!user_i && seg_en)    route_o = ROUTE_SEGMENT;
    else                           route_o = ROUTE_PAGE;
  end
endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
  import seg_xlat_pkg::*;
#(
  parameter int unsigned ADDR_W = seg_xlat_pkg::ADDR_W,
  parameter int unsigned SEG_W  = seg_xlat_pkg::SEG_W,
  parameter int unsigned CFG_W  = seg_xlat_pkg::CFG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              user_i,
  input  logic [CFG_W-1:0]  gcfg_i,
  input  logic [CFG_W-1:0]  mcfg_i,
  input  logic [(1<<SEG_W)/2*SEG_W-1:0] base_lo_i,
  input  logic [(1<<SEG_W)/2*SEG_W-1:0] base_hi_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o,
  output logic              page_lookup_o
);
  localparam int unsigned OFS_W = ADDR_W - SEG_W;
  localparam perm_t PERM_ALL  = '{r: 1'b1, w: 1'b1, x: 1'b1};
  localparam perm_t PERM_NONE = '{r: 1'b0, w: 1'b0, x: 1'b0};

  logic              mmu_on;
  logic [SEG_W-1:0]  seg;
  logic [SEG_W-1:0]  seg_base;
  route_e            route;
  logic [ADDR_W-1:0] paddr_d, paddr_q;
  perm_t             perm_d, perm_q;
  logic              lookup_d, lookup_q;
  logic              valid_q;

  assign seg = vaddr_i[ADDR_W-1 -: SEG_W];

  seg_xlat_enable_dec #(.CFG_W(CFG_W), .EN_LSB(2), .EN_MSB(3)) u_en (
    .gcfg_i   (gcfg_i),
    .mmu_on_o (mmu_on)
  );

  seg_xlat_base_sel #(.SEG_W(SEG_W)) u_base (
    .seg_i     (seg),
    .base_lo_i (base_lo_i),
    .base_hi_i (base_hi_i),
    .base_o    (seg_base)
  );

  seg_xlat_route #(.SEG_W(SEG_W), .CFG_W(CFG_W)) u_route (
    .mmu_on_i (mmu_on),
    .user_i   (user_i),
    .seg_i    (seg),
    .mcfg_i   (mcfg_i),
    .route_o  (route)
  );

  always_comb begin
    unique case (route)
      ROUTE_BYPASS: begin
        paddr_d  = vaddr_i;
        perm_d   = PERM_ALL;
        lookup_d = 1'b0;
      end
      ROUTE_SEGMENT: begin
        paddr_d  = {seg_base, vaddr_i[OFS_W-1:0]};
        perm_d   = PERM_ALL;
        lookup_d = 1'b0;
      end
      default: begin
        paddr_d  = vaddr_i;   // handed on for the page lookup
        perm_d   = PERM_NONE;
        lookup_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      paddr_q  <= '0;
      perm_q   <= PERM_NONE;
      lookup_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        paddr_q  <= paddr_d;
        perm_q   <= perm_d;
        lookup_q <= lookup_d;
      end
    end
  end

  assign valid_o       = valid_q;
  assign paddr_o       = paddr_q;
  assign perm_r_o      = perm_q.r;
  assign perm_w_o      = perm_q.w;
  assign perm_x_o      = perm_q.x;
  assign page_lookup_o = lookup_q;

  p_valid_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  p_off_passthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && gcfg_i[3:2] == 2'b00) |=>
      (paddr_o == $past(vaddr_i) && perm_r_o && perm_w_o && perm_x_o && !page_lookup_o));
  p_user_no_remap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && user_i && gcfg_i[3:2] != 2'b00) |=> page_lookup_o);
  p_remap_offset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && route == ROUTE_SEGMENT) |=>
      (paddr_o[OFS_W-1:0] == $past(vaddr_i[OFS_W-1:0]) && perm_x_o && !page_lookup_o));
  p_lookup_no_perm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_lookup_o |-> (!perm_r_o && !perm_w_o && !perm_x_o));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(paddr_o) && $stable(page_lookup_o) && $stable(perm_w_o)));
endmodule

// File: tb/seg_xlat_top_tb.sv
`timescale 1ns/1ps
module seg_xlat_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] vaddr = '0;
  logic        user = 1'b0;
  logic [31:0] gcfg = '0, mcfg = '0, blo = '0, bhi = '0;
  logic        valid, pr, pw, px, lookup;
  logic [31:0] paddr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  seg_xlat_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(vaddr), .user_i(user),
    .gcfg_i(gcfg), .mcfg_i(mcfg), .base_lo_i(blo), .base_hi_i(bhi),
    .valid_o(valid), .paddr_o(paddr), .perm_r_o(pr), .perm_w_o(pw),
    .perm_x_o(px), .page_lookup_o(lookup)
  );

  task automatic check(string req_tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // one-cycle request issued on a falling edge, result sampled at the next falling edge
  task automatic issue(logic [31:0] va, logic u, logic [31:0] g, logic [31:0] m);
    vaddr = va; user = u; gcfg = g; mcfg = m; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [3:0] exp_base(logic [3:0] s);
    logic [31:0] r = (s < 4'd8) ? blo : bhi;
    return 4'((r >> (4 * (s % 8))) & 32'hF);
  endfunction

  task automatic expect_result(string tag, logic [31:0] pa, logic perm, logic lk);
    check({tag, " valid R2"}, 64'(valid), 64'd1);
    check({tag, " paddr"}, 64'(paddr), 64'(pa));
    check({tag, " perms"}, 64'({pr, pw, px}), 64'({3{perm}}));
    check({tag, " lookup"}, 64'(lookup), 64'(lk));
  endtask

  task automatic t_reset_r1;
    check("R1 valid", 64'(valid), 64'd0);
    check("R1 paddr", 64'(paddr), 64'd0);
    check("R1 perms/lookup", 64'({pr, pw, px, lookup}), 64'd0);
  endtask

  task automatic t_bypass_r4;
    issue(32'hDEAD_BEEF, 1'b0, 32'h0, 32'hFFFF_FFFF);
    expect_result("R4 off", 32'hDEAD_BEEF, 1'b1, 1'b0);
    issue(32'h1234_5678, 1'b1, 32'h0, 32'hFFFF_FFFF);
    expect_result("R4 off user", 32'h1234_5678, 1'b1, 1'b0);
  endtask

  task automatic t_enable_bits_r3;
    issue(32'h3000_0010, 1'b0, 32'hFFFF_FFF3, 32'hFFFF_FFFF);
    expect_result("R3 other bits", 32'h3000_0010, 1'b1, 1'b0);
    issue(32'h3000_0010, 1'b1, 32'h0000_0004, 32'h0);
    expect_result("R3 bit2", 32'h3000_0010, 1'b0, 1'b1);
    issue(32'h3000_0010, 1'b1, 32'h0000_0008, 32'h0);
    expect_result("R3 bit3", 32'h3000_0010, 1'b0, 1'b1);
  endtask

  task automatic t_all_segments_r6;
    blo = 32'hA5C3_1E97; bhi = 32'h2468_BDF0;
    for (int s = 0; s < 16; s++) begin
      logic [31:0] va = {4'(s), 28'h0AB_CDE1 ^ 28'(s * 32'h0111_1111)};
      issue(va, 1'b0, 32'h4, 32'(1) << s);
      expect_result($sformatf("R6 R7 seg%0d", s), {exp_base(4'(s)), va[27:0]}, 1'b1, 1'b0);
    end
  endtask

  task automatic t_seg_disabled_r5;
    issue(32'h5000_1234, 1'b0, 32'hC, ~(32'h1 << 5));
    expect_result("R5 seg off", 32'h5000_1234, 1'b0, 1'b1);
    issue(32'h9876_5432, 1'b0, 32'hC, 32'h0000_0200);
    expect_result("R5 seg on", {exp_base(4'h9), 28'h876_5432}, 1'b1, 1'b0);
  endtask

  task automatic t_user_r8;
    issue(32'hC000_0040, 1'b1, 32'h4, 32'hFFFF_FFFF);
    expect_result("R8 R9 user", 32'hC000_0040, 1'b0, 1'b1);
  endtask

  task automatic t_hold_r10;
    issue(32'hF111_2222, 1'b0, 32'h8, 32'hFFFF);
    expect_result("R10 load", {exp_base(4'hF), 28'h111_2222}, 1'b1, 1'b0);
    vaddr = 32'h0; user = 1'b1; gcfg = 32'h4; mcfg = 32'h0;
    @(negedge clk);
    check("R2 valid falls", 64'(valid), 64'd0);
    @(negedge clk);
    check("R10 paddr held", 64'(paddr), 64'({exp_base(4'hF), 28'h111_2222}));
    check("R10 lookup held", 64'({pr, pw, px, lookup}), 64'b1110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_bypass_r4();
    t_enable_bits_r3();
    t_all_segments_r6();
    t_seg_disabled_r5();
    t_user_r8();
    t_hold_r10();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule